// File: doc/BRIEF.md
# Stereo Sigma-Delta Decimation Filter

This block takes two 1-bit oversampled bitstreams, one for the left channel and one for the right, and turns each into a signed 16-bit PCM sample at one 128th of the bit rate. A qualifier input, `bit_en`, marks the master-clock cycles that carry a new bit on both channels. A master clock of any frequency can therefore serve sample rates from 5 kHz to 48 kHz, because all timing follows the qualifier.

Each channel has its own fourth-order cascaded integrator-comb decimator. A shared phase counter sets the decimation instant once every 128 accepted bits. On that instant each comb result is rounded, scaled down to 16 bits and clamped. The two words are registered together, and a single-cycle `pcm_valid` pulse marks the new pair.

Top module: `sd_decim_stereo`

## Requirements
- R1: A clock edge with `rst` high clears every integrator, comb delay, the phase counter and the output registers. From the next cycle on, `pcm_valid` is 0 and `pcm_l`/`pcm_r` are 0.
- R2: An input bit of 1 counts as +1 and a bit of 0 counts as -1. A long run of ones settles at 32767 and a long run of zeros settles at -32768.
- R3: The raw filter sum is scaled by adding 4096 and shifting right arithmetically by 13 bits, which rounds half up. The result is then clamped to [-32768, 32767], so a full-scale positive run (raw sum +2^28) gives 32767.
- R4: `pcm_valid` is high for exactly one cycle, in the cycle after each 128th accepted bit counted from reset. It is low in every other cycle.
- R5: While `bit_en` is low, the values on `bit_l`/`bit_r` are ignored and the decimation phase does not advance.
- R6: Each output equals the sum over j = 0..508 of h[j]·x[n-j], scaled as in R3. Here h[j] are the coefficients of (1 + z^-1 + ... + z^-127)^4, n is the index of the 128th accepted bit, and bits before reset count as 0.
- R7: The left and right outputs depend only on their own bitstream.
- R8: A reset in the middle of a period restarts the phase. After it, the first `pcm_valid` comes only after 128 further accepted bits.
- R9: The integrators wrap modulo 2^30 without harm. Arbitrarily long constant runs still give the correct output, for example 32767 after 40 periods of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High in the cycles that carry a new bit on both channels |
| bit_l | input | 1 | Left-channel modulator bit |
| bit_r | input | 1 | Right-channel modulator bit |
| pcm_l | output | 16 | Left sample, signed two's complement |
| pcm_r | output | 16 | Right sample, signed two's complement |
| pcm_valid | output | 1 | One-cycle pulse marking a new sample pair |

## Verification
The hardest condition to reach is integrator wraparound that only cancels out correctly in the combs. It happens only after hundreds of same-valued bits, so the stimulus includes a run of 40 periods of ones, plus shorter full-scale runs of both polarities that also push the rounding into saturation. A bench first-order modulator driven with random levels produces realistic mid-scale streams that differ between channels. Random gaps in `bit_en`, with junk on the data pins, and a reset partway through a period exercise the phase logic.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;
   // Register width that holds the full CIC growth plus a sign bit and
   // one bit of headroom so the exact +R^N full-scale value fits.
   function automatic int acc_width(input int order, input int log2r);
      return order * log2r + 2;
   endfunction

   // Right shift that maps the CIC gain R^N onto the output word range.
   function automatic int scale_shift(input int order, input int log2r, input int out_w);
      return order * log2r - (out_w - 1);
   endfunction
endpackage

// File: rtl/sd_cic_integ.sv
module sd_cic_integ #(
   parameter int ORDER = 4,
   parameter int W     = 30
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic                bit_in,
   output logic signed [W-1:0] sum_next
);
   logic signed [W-1:0] acc [ORDER];
   logic signed [W-1:0] nxt [ORDER];
   logic signed [W-1:0] x;

   // bit 1 -> +1, bit 0 -> -1
   assign x = bit_in ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};

   always_comb begin
      nxt[0] = acc[0] + x;
      for (int k = 1; k < ORDER; k++) begin
         nxt[k] = acc[k] + nxt[k-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) acc[k] <= '0;
      end else if (en) begin
         for (int k = 0; k < ORDER; k++) acc[k] <= nxt[k];
      end
   end

   assign sum_next = nxt[ORDER-1];

   // R5: no accepted bit, no change in the last integrator
   assert_integ_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc[ORDER-1]));

   // R2: each accepted bit moves the first integrator by exactly +1 or -1 (mod 2^W)
   assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
      en |=> (W'(acc[0] - $past(acc[0])) == W'(1)) ||
             (W'(acc[0] - $past(acc[0])) == {W{1'b1}}));
endmodule

// File: rtl/sd_cic_comb.sv
module sd_cic_comb #(
   parameter int ORDER = 4,
   parameter int W     = 30
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load,
   input  logic signed [W-1:0] sample_in,
   output logic signed [W-1:0] comb_out
);
   logic signed [W-1:0] dly [ORDER];
   logic signed [W-1:0] dif [ORDER];

   always_comb begin
      dif[0] = sample_in - dly[0];
      for (int k = 1; k < ORDER; k++) begin
         dif[k] = dif[k-1] - dly[k];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < ORDER; k++) dly[k] <= '0;
      end else if (load) begin
         dly[0] <= sample_in;
         for (int k = 1; k < ORDER; k++) dly[k] <= dif[k-1];
      end
   end

   assign comb_out = dif[ORDER-1];

   // R5: comb delays move only at a decimation instant
   assert_comb_hold_R5: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(dly[ORDER-1]));
endmodule

// File: rtl/sd_round_sat.sv
module sd_round_sat #(
   parameter int IN_W  = 30,
   parameter int SHIFT = 13,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);
   localparam int Q_W = IN_W - SHIFT;
   localparam logic [IN_W-1:0] HALF = {{(IN_W-1){1'b0}}, 1'b1} << (SHIFT - 1);

   if (SHIFT < 1 || Q_W <= OUT_W) begin : g_bad_cfg
      $error("sd_round_sat: SHIFT must be >= 1 and IN_W - SHIFT must exceed OUT_W");
   end

   logic signed [IN_W-1:0] biased;
   logic signed [Q_W-1:0]  q;
   logic                   in_range;

   assign biased   = din + $signed(HALF);
   assign q        = Q_W'(biased >>> SHIFT);
   assign in_range = (&q[Q_W-1:OUT_W-1]) || !(|q[Q_W-1:OUT_W-1]);

   always_comb begin
      if (in_range)       dout = q[OUT_W-1:0];
      else if (q[Q_W-1])  dout = {1'b1, {(OUT_W-1){1'b0}}};
      else                dout = {1'b0, {(OUT_W-1){1'b1}}};
   end
endmodule

// File: rtl/sd_decim_stereo.sv
module sd_decim_stereo #(
   parameter int ORDER  = 4,
   parameter int LOG2_R = 7,
   parameter int OUT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    bit_en,
   input  logic                    bit_l,
   input  logic                    bit_r,
   output logic signed [OUT_W-1:0] pcm_l,
   output logic signed [OUT_W-1:0] pcm_r,
   output logic                    pcm_valid
);
   localparam int ACC_W = sd_decim_pkg::acc_width(ORDER, LOG2_R);
   localparam int SHIFT = sd_decim_pkg::scale_shift(ORDER, LOG2_R, OUT_W);
   localparam int NCH   = 2;

   if (ORDER < 1 || LOG2_R < 1 || OUT_W < 2) begin : g_bad_dims
      $error("sd_decim_stereo: ORDER, LOG2_R and OUT_W out of range");
   end
   if (SHIFT < 1) begin : g_bad_gain
      $error("sd_decim_stereo: ORDER*LOG2_R must be at least OUT_W");
   end

   logic [LOG2_R-1:0]       phase;
   logic                    last_bit;
   logic [NCH-1:0]          bits;
   logic signed [OUT_W-1:0] scaled [NCH];

   assign last_bit = bit_en && (phase == '1);
   assign bits     = {bit_r, bit_l};

   always_ff @(posedge clk) begin
      if (rst)          phase <= '0;
      else if (bit_en)  phase <= phase + LOG2_R'(1);
   end

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic signed [ACC_W-1:0] integ_sum;
      logic signed [ACC_W-1:0] comb_val;

      sd_cic_integ #(.ORDER(ORDER), .W(ACC_W)) u_integ (
         .clk      (clk),
         .rst      (rst),
         .en       (bit_en),
         .bit_in   (bits[ch]),
         .sum_next (integ_sum)
      );

      sd_cic_comb #(.ORDER(ORDER), .W(ACC_W)) u_comb (
         .clk       (clk),
         .rst       (rst),
         .load      (last_bit),
         .sample_in (integ_sum),
         .comb_out  (comb_val)
      );

      sd_round_sat #(.IN_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_scale (
         .din  (comb_val),
         .dout (scaled[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pcm_l     <= '0;
         pcm_r     <= '0;
         pcm_valid <= 1'b0;
      end else begin
         pcm_valid <= last_bit;
         if (last_bit) begin
            pcm_l <= scaled[0];
            pcm_r <= scaled[1];
         end
      end
   end

   // R1: outputs cleared one cycle after a reset edge
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!pcm_valid && pcm_l == '0 && pcm_r == '0));

   // R4: the 128th accepted bit always produces a pulse
   assert_pulse_after_last_R4: assert property (@(posedge clk) disable iff (rst)
      last_bit |=> pcm_valid);

   // R4: a pulse never lasts two cycles
   assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
      pcm_valid |=> !pcm_valid);

   // R8: every pulse traces back to a completed period since reset
   assert_pulse_origin_R8: assert property (@(posedge clk) disable iff (rst)
      pcm_valid |-> $past(last_bit));
endmodule

// File: tb/sd_decim_stereo_bench.sv
module sd_decim_stereo_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int R     = 128;
   localparam int KLEN  = 4 * (R - 1) + 1;
   localparam int HMAX  = 32768;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_en = 1'b0;
   logic bit_l = 1'b0;
   logic bit_r = 1'b0;
   logic signed [15:0] pcm_l, pcm_r;
   logic pcm_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int nbits = 0;
   int hist_l [HMAX];
   int hist_r [HMAX];
   longint h [KLEN];

   always #10 clk = ~clk;  // 50 MHz

   sd_decim_stereo u_sd_decim_stereo (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_l(bit_l), .bit_r(bit_r),
      .pcm_l(pcm_l), .pcm_r(pcm_r), .pcm_valid(pcm_valid)
   );

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // kernel = (boxcar of length R) convolved with itself four times
   task automatic build_kernel();
      longint tmp [KLEN];
      for (int j = 0; j < KLEN; j++) h[j] = (j < R) ? 1 : 0;
      for (int s = 1; s < 4; s++) begin
         for (int j = 0; j < KLEN; j++) begin
            longint acc = 0;
            for (int k = 0; k < R; k++) if (j - k >= 0) acc += h[j-k];
            tmp[j] = acc;
         end
         for (int j = 0; j < KLEN; j++) h[j] = tmp[j];
      end
   endtask

   function automatic longint expect_pcm(input int ch, input int n);
      longint s = 0;
      longint q;
      for (int j = 0; j < KLEN; j++) begin
         if (n - j >= 0) s += h[j] * longint'(ch == 0 ? hist_l[n-j] : hist_r[n-j]);
      end
      q = (s + 4096) >>> 13;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   task automatic push(input logic en, input logic bl, input logic br);
      bit_en = en; bit_l = bl; bit_r = br;
      @(posedge clk);
      @(negedge clk);
      bit_en = 1'b0;
      if (en && nbits < HMAX) begin
         hist_l[nbits] = bl ? 1 : -1;
         hist_r[nbits] = br ? 1 : -1;
         nbits++;
      end
      if (en && (nbits % R) == 0) begin
         longint el = expect_pcm(0, nbits - 1);
         longint er = expect_pcm(1, nbits - 1);
         check(pcm_valid === 1'b1, "R4 pulse after 128th bit", longint'(pcm_valid), 1);
         check(longint'(pcm_l) == el, "R6 left filter output", longint'(pcm_l), el);
         check(longint'(pcm_r) == er, "R7 right filter output", longint'(pcm_r), er);
      end else begin
         check(pcm_valid === 1'b0, en ? "R4 no pulse mid-period" : "R5 idle cycle",
               longint'(pcm_valid), 0);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; bit_en = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      nbits = 0;
      check(pcm_valid === 1'b0, "R1 valid after reset", longint'(pcm_valid), 0);
      check(pcm_l == 0 && pcm_r == 0, "R1 pcm after reset", longint'(pcm_l), 0);
   endtask

   task automatic const_frames(input int frames, input logic bl, input logic br);
      for (int i = 0; i < frames * R; i++) push(1'b1, bl, br);
   endtask

   // first-order modulator per channel with a random level per period
   task automatic mod_frames(input int frames);
      int el = 0, er = 0;
      for (int f = 0; f < frames; f++) begin
         int ul = int'($urandom_range(1800)) - 900;
         int ur = int'($urandom_range(1800)) - 900;
         for (int i = 0; i < R; i++) begin
            logic bl = (el + ul >= 0);
            logic br = (er + ur >= 0);
            el = el + ul - (bl ? 1024 : -1024);
            er = er + ur - (br ? 1024 : -1024);
            push(1'b1, bl, br);
         end
      end
   endtask

   task automatic gapped_frames(input int frames);
      int got = 0;
      while (got < frames * R) begin
         logic en = ($urandom_range(9) < 6);
         push(en, 1'($urandom_range(1)), 1'($urandom_range(1)));
         if (en) got++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      build_kernel();
      repeat (2) @(negedge clk);
      do_reset();                        // R1

      mod_frames(4);                     // R6, R7 from a cold start
      const_frames(6, 1'b1, 1'b1);       // R2, R3 positive full scale
      check(pcm_l == 16'sd32767, "R3 positive clamp", longint'(pcm_l), 32767);
      const_frames(6, 1'b0, 1'b0);       // R2 negative full scale
      check(pcm_l == -16'sd32768 && pcm_r == -16'sd32768, "R2 zeros map to -1",
            longint'(pcm_r), -32768);
      const_frames(5, 1'b1, 1'b0);       // R7 opposite channels
      check(pcm_l == 16'sd32767 && pcm_r == -16'sd32768, "R7 channel isolation",
            longint'(pcm_r), -32768);
      mod_frames(25);                    // R6 random levels
      gapped_frames(10);                 // R5 junk while disabled
      const_frames(40, 1'b1, 1'b1);      // R9 long wrapping run
      check(pcm_l == 16'sd32767 && pcm_r == 16'sd32767, "R9 wrap run",
            longint'(pcm_l), 32767);

      for (int i = 0; i < 50; i++) push(1'b1, 1'($urandom_range(1)), 1'b1);
      do_reset();                        // R8 reset mid-period
      for (int i = 0; i < R - 1; i++) push(1'b1, 1'b1, 1'b0);
      check(pcm_valid === 1'b0, "R8 no early pulse", longint'(pcm_valid), 0);
      push(1'b1, 1'b1, 1'b0);            // 128th bit: pulse checked in push
      mod_frames(4);
      finish_run();
   end
endmodule